// File: doc/BRIEF.md
# Auto-Incrementing SRAM Address Pointer

This block keeps the 21-bit byte address of a paged memory disk built from sixteen 128K×8 static RAM devices, and produces the signals those devices need: a shared 17-bit device address and one active-low select per device. Host software sets the address in three parts.

The middle byte and the top five bits are each loaded by a dedicated port write. The top-bits write also sets a select-enable flag. The low byte is a counter that advances on the rising edge of every data-port access, so a run of consecutive bytes can be streamed without reloading the address.

The counter does not drive the devices directly. A holding register copies it on each rising edge of the system clock, and only that register reaches the device address pins. If two data accesses complete with no clock edge between them, the address visible to the devices moves by two. One location is skipped, and this block models that exactly. A strobe on the clear port, or power-on reset, returns the counter to zero.

Top module: `sram_addr_ptr`

## Requirements
- R1: Each rising edge of `data_stb` adds one to the low-byte counter. After the next rising edge of `clk`, `dev_addr[7:0]` shows the new value.
- R2: `dev_addr[7:0]` changes only at a rising edge of `clk`, where it takes the counter value. Between clock edges it holds, even when `data_stb` pulses.
- R3: Two `data_stb` rising edges with no `clk` rising edge between them make `dev_addr[7:0]` advance by two at the next clock edge. The intermediate address never appears.
- R4: A high pulse on `clr_stb` zeroes the counter. `dev_addr[7:0]` reads 0 after the next `clk` rising edge.
- R5: The rising edge of `mid_wr` loads `wdata[7:0]` into address bits 15..8, which appear on `dev_addr[15:8]` at once. Without that edge, these bits hold.
- R6: The rising edge of `hi_wr` loads `wdata[4:0]` into address bits 20..16 and `wdata[5]` into the select enable. Address bit 16 appears on `dev_addr[16]`. `wdata[7:6]` have no effect on any output.
- R7: While the enable is 1 and `data_stb` is high, exactly one select is low: `dev_sel_n[k]`, where k is address bits 20..17 read as an unsigned number.
- R8: While the enable is 0, or while `data_stb` is low, all sixteen `dev_sel_n` bits are 1.
- R9: The counter wraps from 0xFF to 0x00 and leaves address bits 15..8 unchanged.
- R10: While `rst_n` is low, the block holds `dev_addr` at 0 and every `dev_sel_n` bit at 1. Reset clears the counter, the holding register, the middle byte, the top bits and the enable.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; its rising edge copies the counter to the holding register |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| data_stb | input | 1 | Data-port access strobe, high during the access; rising edge advances the counter |
| clr_stb | input | 1 | Clear-port strobe, high clears the counter |
| mid_wr | input | 1 | Middle-byte write strobe, rising edge loads |
| hi_wr | input | 1 | Top-bits/enable write strobe, rising edge loads |
| wdata | input | 8 | Internal data byte |
| dev_addr | output | 17 | Address shared by all memory devices |
| dev_sel_n | output | 16 | One-hot active-low device selects |

## Verification
The counter is driven three ways. Single accesses, one per clock, show normal stepping. Pairs of accesses inside one clock half-period separate a design that stages the count through the clock from one that drives the counter straight out. A run of 256 accesses crosses the 0xFF boundary and exposes any carry into the middle byte.

Top-bit writes sweep all sixteen decode values with the enable on, then repeat with the enable off. Each select is sampled while the strobe is high, which catches wrong decode order and ignored gating. Writes that set only bits 7..6 must leave every output unchanged.

// File: rtl/sram_addr_ptr.sv
`timescale 1ns/100ps
module sram_addr_ptr #(
  parameter int LO_W  = 8,
  parameter int MID_W = 8,
  parameter int HI_W  = 5,
  parameter int DEV_AW = 17
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                data_stb,
  input  logic                clr_stb,
  input  logic                mid_wr,
  input  logic                hi_wr,
  input  logic [7:0]          wdata,
  output logic [DEV_AW-1:0]   dev_addr,
  output logic [(1<<(LO_W+MID_W+HI_W-DEV_AW))-1:0] dev_sel_n
);
  localparam int TOT_W = LO_W + MID_W + HI_W;
  localparam int IDX_W = TOT_W - DEV_AW;
  localparam int NDEV  = 1 << IDX_W;

  logic [LO_W-1:0]  lo_cnt, lo_q;
  logic [MID_W-1:0] mid_q;
  logic [HI_W-1:0]  hi_q;
  logic             sel_en;
  logic [TOT_W-1:0] full_addr;
  logic [IDX_W-1:0] dev_idx;
  logic             cnt_clr;

  assign cnt_clr = clr_stb | ~rst_n;

  always_ff @(posedge data_stb or posedge cnt_clr)
    if (cnt_clr) lo_cnt <= '0;
    else         lo_cnt <= lo_cnt + 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) lo_q <= '0;
    else        lo_q <= lo_cnt;

  always_ff @(posedge mid_wr or negedge rst_n)
    if (!rst_n) mid_q <= '0;
    else        mid_q <= wdata[MID_W-1:0];

  always_ff @(posedge hi_wr or negedge rst_n)
    if (!rst_n) begin
      hi_q   <= '0;
      sel_en <= 1'b0;
    end else begin
      hi_q   <= wdata[HI_W-1:0];
      sel_en <= wdata[HI_W];
    end

  assign full_addr = {hi_q, mid_q, lo_q};
  assign dev_addr  = full_addr[DEV_AW-1:0];
  assign dev_idx   = full_addr[TOT_W-1:DEV_AW];

  for (genvar k = 0; k < NDEV; k++) begin : g_sel
    assign dev_sel_n[k] = ~(sel_en & data_stb & (dev_idx == IDX_W'(k)));
  end
endmodule

module sram_addr_ptr_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        data_stb,
  input logic        mid_wr,
  input logic        hi_wr,
  input logic [16:0] dev_addr,
  input logic [15:0] dev_sel_n
);
  logic [7:0] mid_edges, hi_edges;

  always_ff @(posedge mid_wr or negedge rst_n)
    if (!rst_n) mid_edges <= '0;
    else        mid_edges <= mid_edges + 1'b1;

  always_ff @(posedge hi_wr or negedge rst_n)
    if (!rst_n) hi_edges <= '0;
    else        hi_edges <= hi_edges + 1'b1;

  AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(~dev_sel_n) <= 1); // R7
  AST_SEL_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !data_stb |-> &dev_sel_n); // R8
  AST_MID_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    $stable(mid_edges) |-> $stable(dev_addr[15:8])); // R5
  AST_HI_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    $stable(hi_edges) |-> $stable(dev_addr[16])); // R6

  always_ff @(posedge clk)
    if (!rst_n) AST_RESET_CLEAR: assert (dev_addr == '0 && &dev_sel_n); // R10
endmodule

bind sram_addr_ptr sram_addr_ptr_chk u_chk (
  .clk(clk), .rst_n(rst_n), .data_stb(data_stb), .mid_wr(mid_wr),
  .hi_wr(hi_wr), .dev_addr(dev_addr), .dev_sel_n(dev_sel_n));

// File: tb/sram_addr_ptr_tb.sv
`timescale 1ns/100ps
module sram_addr_ptr_tb;
  logic clk = 0, rst_n = 0;
  logic data_stb = 0, clr_stb = 0, mid_wr = 0, hi_wr = 0;
  logic [7:0]  wdata = 0;
  logic [16:0] dev_addr;
  logic [15:0] dev_sel_n;

  int checks = 0, errors = 0;
  int m_cnt = 0, m_lo = 0, m_mid = 0, m_hi = 0, m_en = 0;
  bit running = 1;

  sram_addr_ptr u_dut (.clk(clk), .rst_n(rst_n), .data_stb(data_stb),
    .clr_stb(clr_stb), .mid_wr(mid_wr), .hi_wr(hi_wr), .wdata(wdata),
    .dev_addr(dev_addr), .dev_sel_n(dev_sel_n));

  always #2 clk = ~clk;

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  // reference: holding register follows the counter on each clock edge
  always @(posedge clk) begin
    if (!rst_n) m_lo = 0; else m_lo = m_cnt;
    #1;
    if (rst_n && running) begin
      chk("R2 low byte", dev_addr[7:0], m_lo);
      chk("R5 mid byte", dev_addr[15:8], m_mid);
      chk("R6 bit16", dev_addr[16], m_hi & 1);
      chk("R8 idle selects", dev_sel_n, 16'hFFFF);
    end
  end

  function automatic int exp_sel();
    return m_en ? (~(1 << (m_hi >> 1))) & 16'hFFFF : 16'hFFFF;
  endfunction

  task automatic access(string req);
    @(negedge clk); #0.3 data_stb = 1; m_cnt = (m_cnt + 1) & 255;
    #0.3 chk(req, dev_sel_n, exp_sel());
    #0.3 data_stb = 0;
  endtask

  task automatic access_pair();   // R3: two edges inside one half period
    @(negedge clk);
    #0.2 data_stb = 1; #0.3 data_stb = 0; m_cnt = (m_cnt + 1) & 255;
    #0.3 chk("R2 hold between edges", dev_addr[7:0], m_lo);
    #0.2 data_stb = 1; #0.3 data_stb = 0; m_cnt = (m_cnt + 1) & 255;
  endtask

  task automatic wr_mid(int v);
    @(negedge clk); wdata = v[7:0]; #0.3 mid_wr = 1; m_mid = v & 255;
    #0.4 mid_wr = 0;
  endtask

  task automatic wr_hi(int v);
    @(negedge clk); wdata = v[7:0]; #0.3 hi_wr = 1; m_hi = v & 31; m_en = (v >> 5) & 1;
    #0.4 hi_wr = 0;
  endtask

  task automatic clear();
    @(negedge clk); #0.3 clr_stb = 1; m_cnt = 0; #0.4 clr_stb = 0;
  endtask

  initial begin
    #40000;
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #1 chk("R10 reset addr", dev_addr, 0);
    chk("R10 reset selects", dev_sel_n, 16'hFFFF);
    repeat (3) @(posedge clk);
    #0.5 rst_n = 1;
    #1 chk("R10 after reset", dev_addr, 0);
    // R1 single accesses
    for (int i = 0; i < 5; i++) access("R8 enable off");
    @(posedge clk); #1 chk("R1 count 5", dev_addr[7:0], 5);
    // R3 skip
    access_pair();
    @(posedge clk); #1 chk("R3 jump by two", dev_addr[7:0], 7);
    // R4 clear
    clear();
    @(posedge clk); #1 chk("R4 cleared", dev_addr[7:0], 0);
    // R5 / R6 / R7 sweep
    wr_mid(8'hA5);
    for (int k = 0; k < 32; k++) begin
      wr_hi(32 | k);
      access("R7 decode");
    end
    // R6: bits 7..6 do not reach outputs
    wr_hi(8'h20 | 8'h0B);
    access("R7 before high-bit write");
    wr_hi(8'hC0 | 8'h20 | 8'h0B);
    access("R6 upper bits ignored");
    @(posedge clk); #1 chk("R6 addr unchanged", dev_addr[16], 1);
    // R8 enable off
    wr_hi(8'h1F);
    access("R8 disabled");
    // R9 wrap
    clear();
    wr_mid(8'h3C);
    for (int i = 0; i < 256; i++) access("R7 wrap run");
    @(posedge clk); #1 chk("R9 wrapped low", dev_addr[7:0], 0);
    chk("R9 mid kept", dev_addr[15:8], 8'h3C);
    repeat (3) @(posedge clk);
    running = 0;
    #2;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule